// File: doc/BRIEF.md
# Interline CCD Timing Generator

This block turns a master clock into the logic-level drive patterns of an interline CCD image sensor. One frame is produced per start request. The frame runs in a fixed order. An optional shutter pulse on the substrate comes first, followed by a guard gap. Then comes the photodiode transfer preamble: a lead pedestal, phase 1 at its high level, and a trail pedestal. The frame then reads out line by line. Each line is one vertical transfer step, or two back to back when binning by two, then a settle delay, then a run of pixels on the two horizontal phases with a reset gate pulse.

Every interval is a tick count sampled when the frame starts. A count below its minimum is raised to that minimum, so no setting can produce a pulse shorter than the sensor allows. A mode input picks the short geometry or the long one. The outputs are level-select codes for external analog drivers. Phase 1 uses three levels, so it needs a two-bit code.

Top module: `ccd_timing_gen`

## Requirements
- R1: While reset is low and after it is released, the outputs hold the rest pattern: v1_lvl = MID (2'b01), v2 = 1, v3 = v4 = 0, h1 = h2 = h2_last = rst_gate = 0, shutter = 0, busy = 0.
- R2: A start seen while idle raises busy at the next edge. The block samples the mode, binning, shutter enable and all tick counts at that edge. A start, or any change to these inputs, while busy has no effect on the running frame.
- R3: The preamble is three phases in order. First, MID for t_ped ticks. Second, HIGH (2'b10) for t_xfer ticks. Third, MID with v4 = 1 for t_ped ticks. Phase 1 only enters HIGH from MID, and v4 rises in the same cycle that phase 1 leaves HIGH.
- R4: Any tick count below its minimum lasts exactly the minimum. The pixel period is never shorter than 2 ticks.
- R5: A vertical transfer step is four sub-steps of t_vstep ticks each. As {v1_lvl,v2,v3,v4} they are {MID,1,1,0}, {LOW,1,1,0}, {LOW,0,1,1} and {MID,0,0,1}. The row enters the horizontal register when phase 1 falls in sub-step 1.
- R6: With bin2 set, each line has eight sub-steps, the R5 sequence twice, and the number of lines read out is half the mode's line count.
- R7: After each line's vertical transfer, all vertical and horizontal outputs hold the rest pattern for t_hdly ticks before the first pixel.
- R8: A pixel takes t_hper ticks. h1 is high for the first ceil(t_hper/2) ticks and h2 for the rest. h2_last equals h2, and rst_gate is high in the first tick only. Outside the pixel phase, h1, h2, h2_last and rst_gate are low.
- R9: The short mode (long_mode = 0) reads SHORT_LINES lines of SHORT_PIX pixels. The long mode reads LONG_LINES lines of LONG_PIX pixels.
- R10: With shutter_en set, shutter is high for t_shut ticks, then all outputs rest for t_gap ticks, then the preamble begins. With shutter_en clear, shutter never rises and the preamble starts at once.
- R11: busy falls in the cycle after the last tick of the last pixel of the last line, and the rest pattern returns at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, honoured while idle |
| long_mode | input | 1 | 1 selects the long geometry |
| bin2 | input | 1 | 1 selects vertical binning by two |
| shutter_en | input | 1 | 1 adds the substrate shutter pulse |
| t_xfer | input | TW | Photodiode transfer high time in ticks |
| t_ped | input | TW | Lead and trail pedestal length in ticks |
| t_vstep | input | TW | Length of one vertical sub-step in ticks |
| t_hdly | input | TW | Delay before the first pixel in ticks |
| t_hper | input | TW | Pixel period in ticks |
| t_shut | input | TW | Shutter pulse length in ticks |
| t_gap | input | TW | Guard gap after the shutter in ticks |
| v1_lvl | output | 2 | Phase 1 level code: LOW 00, MID 01, HIGH 10 |
| v2 | output | 1 | Vertical phase 2 |
| v3 | output | 1 | Vertical phase 3 |
| v4 | output | 1 | Vertical phase 4 |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| h2_last | output | 1 | Last horizontal phase, falls when a pixel is shifted out |
| rst_gate | output | 1 | Output reset gate pulse |
| shutter | output | 1 | Substrate shutter pulse |
| busy | output | 1 | High from frame start until the last pixel ends |

## Verification
Two events share a clock edge at the end of each line. The tick that shifts the last pixel out is also the tick that decides between the next vertical step and the return to idle. The bench uses geometries of a few lines so that both outcomes occur in every frame. It checks each cycle against a pattern computed from the requirements, so a step inserted or lost at that edge shows up at once. Frame start is provoked a second time while a frame is running, together with changed tick counts. The frame is judged unaltered only if every later cycle still matches the counts sampled at the first start.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SHUT, ST_GAP, ST_PLEAD, ST_PXFER,
    ST_PTRAIL, ST_VSTEP, ST_HDLY, ST_HREAD
  } tg_state_e;

  localparam logic [1:0] V1_LOW  = 2'b00;
  localparam logic [1:0] V1_MID  = 2'b01;
  localparam logic [1:0] V1_HIGH = 2'b10;

  typedef struct packed {
    logic [1:0] v1;
    logic       v2;
    logic       v3;
    logic       v4;
  } vlev_t;

  function automatic vlev_t rest_levels();
    vlev_t l;
    l.v1 = V1_MID; l.v2 = 1'b1; l.v3 = 1'b0; l.v4 = 1'b0;
    return l;
  endfunction

  // four-step rotation; each rising edge coincides with a falling one
  function automatic vlev_t step_levels(input logic [1:0] sub);
    vlev_t l;
    case (sub)
      2'd0:    begin l.v1 = V1_MID; l.v2 = 1'b1; l.v3 = 1'b1; l.v4 = 1'b0; end
      2'd1:    begin l.v1 = V1_LOW; l.v2 = 1'b1; l.v3 = 1'b1; l.v4 = 1'b0; end
      2'd2:    begin l.v1 = V1_LOW; l.v2 = 1'b0; l.v3 = 1'b1; l.v4 = 1'b1; end
      default: begin l.v1 = V1_MID; l.v2 = 1'b0; l.v3 = 1'b0; l.v4 = 1'b1; end
    endcase
    return l;
  endfunction

endpackage

// File: rtl/ccdtg_cfg_latch.sv
module ccdtg_cfg_latch #(
  parameter int TW          = 12,
  parameter int MIN_XFER    = 40,
  parameter int MIN_PED     = 160,
  parameter int MIN_VSTEP   = 40,
  parameter int MIN_HDLY    = 8,
  parameter int MIN_HPER    = 2,
  parameter int MIN_SHUT    = 40,
  parameter int MIN_GAP     = 40,
  parameter int SHORT_LINES = 532,
  parameter int SHORT_PIX   = 553,
  parameter int LONG_LINES  = 1064,
  parameter int LONG_PIX    = 1106,
  parameter int LW          = 11,
  parameter int PW          = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          long_mode,
  input  logic          bin2,
  input  logic [TW-1:0] t_xfer,
  input  logic [TW-1:0] t_ped,
  input  logic [TW-1:0] t_vstep,
  input  logic [TW-1:0] t_hdly,
  input  logic [TW-1:0] t_hper,
  input  logic [TW-1:0] t_shut,
  input  logic [TW-1:0] t_gap,
  output logic [TW-1:0] c_xfer,
  output logic [TW-1:0] c_ped,
  output logic [TW-1:0] c_vstep,
  output logic [TW-1:0] c_hdly,
  output logic [TW-1:0] c_hper,
  output logic [TW-1:0] c_shut,
  output logic [TW-1:0] c_gap,
  output logic [LW-1:0] c_lines,
  output logic [PW-1:0] c_pix,
  output logic          c_bin
);

  localparam int FL_XFER  = (MIN_XFER  < 1) ? 1 : MIN_XFER;
  localparam int FL_PED   = (MIN_PED   < 1) ? 1 : MIN_PED;
  localparam int FL_VSTEP = (MIN_VSTEP < 1) ? 1 : MIN_VSTEP;
  localparam int FL_HDLY  = (MIN_HDLY  < 1) ? 1 : MIN_HDLY;
  localparam int FL_HPER  = (MIN_HPER  < 2) ? 2 : MIN_HPER;
  localparam int FL_SHUT  = (MIN_SHUT  < 1) ? 1 : MIN_SHUT;
  localparam int FL_GAP   = (MIN_GAP   < 1) ? 1 : MIN_GAP;

  function automatic logic [TW-1:0] clamp_tick(input logic [TW-1:0] v, input int floor_v);
    logic [TW-1:0] f;
    f = TW'(floor_v);
    return (v < f) ? f : v;
  endfunction

  function automatic logic [LW-1:0] line_total(input logic lm, input logic b);
    logic [LW-1:0] n;
    n = lm ? LW'(LONG_LINES) : LW'(SHORT_LINES);
    return b ? (n >> 1) : n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_xfer <= TW'(FL_XFER);   c_ped  <= TW'(FL_PED);
      c_vstep <= TW'(FL_VSTEP); c_hdly <= TW'(FL_HDLY);
      c_hper <= TW'(FL_HPER);   c_shut <= TW'(FL_SHUT);
      c_gap  <= TW'(FL_GAP);
      c_lines <= LW'(SHORT_LINES);
      c_pix   <= PW'(SHORT_PIX);
      c_bin   <= 1'b0;
    end else if (load) begin
      c_xfer  <= clamp_tick(t_xfer,  FL_XFER);
      c_ped   <= clamp_tick(t_ped,   FL_PED);
      c_vstep <= clamp_tick(t_vstep, FL_VSTEP);
      c_hdly  <= clamp_tick(t_hdly,  FL_HDLY);
      c_hper  <= clamp_tick(t_hper,  FL_HPER);
      c_shut  <= clamp_tick(t_shut,  FL_SHUT);
      c_gap   <= clamp_tick(t_gap,   FL_GAP);
      c_lines <= line_total(long_mode, bin2);
      c_pix   <= long_mode ? PW'(LONG_PIX) : PW'(SHORT_PIX);
      c_bin   <= bin2;
    end
  end

endmodule

// File: rtl/ccdtg_vdrive.sv
module ccdtg_vdrive
  import ccdtg_pkg::*;
(
  input  tg_state_e  st,
  input  logic [1:0] sub,
  output vlev_t      lev
);

  always_comb begin
    lev = rest_levels();
    case (st)
      ST_PXFER:  lev.v1 = V1_HIGH;
      ST_PTRAIL: lev.v4 = 1'b1;
      ST_VSTEP:  lev = step_levels(sub);
      default:   ;
    endcase
  end

endmodule

// File: rtl/ccdtg_hclk.sv
module ccdtg_hclk #(
  parameter int TW = 12
) (
  input  logic          active,
  input  logic [TW-1:0] phase,
  input  logic [TW-1:0] hper,
  output logic          h1,
  output logic          h2,
  output logic          h2l,
  output logic          rg
);

  logic [TW:0] first_half;

  always_comb begin
    first_half = ({1'b0, hper} + (TW+1)'(1)) >> 1;
    h1  = active && ({1'b0, phase} < first_half);
    h2  = active && !h1;
    h2l = h2;
    rg  = active && (phase == '0);
  end

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccdtg_pkg::*;
#(
  parameter int TW          = 12,
  parameter int MIN_XFER    = 40,
  parameter int MIN_PED     = 160,
  parameter int MIN_VSTEP   = 40,
  parameter int MIN_HDLY    = 8,
  parameter int MIN_HPER    = 2,
  parameter int MIN_SHUT    = 40,
  parameter int MIN_GAP     = 40,
  parameter int SHORT_LINES = 532,
  parameter int SHORT_PIX   = 553,
  parameter int LONG_LINES  = 1064,
  parameter int LONG_PIX    = 1106
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          long_mode,
  input  logic          bin2,
  input  logic          shutter_en,
  input  logic [TW-1:0] t_xfer,
  input  logic [TW-1:0] t_ped,
  input  logic [TW-1:0] t_vstep,
  input  logic [TW-1:0] t_hdly,
  input  logic [TW-1:0] t_hper,
  input  logic [TW-1:0] t_shut,
  input  logic [TW-1:0] t_gap,
  output logic [1:0]    v1_lvl,
  output logic          v2,
  output logic          v3,
  output logic          v4,
  output logic          h1,
  output logic          h2,
  output logic          h2_last,
  output logic          rst_gate,
  output logic          shutter,
  output logic          busy
);

  localparam int MAXL = (LONG_LINES > SHORT_LINES) ? LONG_LINES : SHORT_LINES;
  localparam int MAXP = (LONG_PIX > SHORT_PIX) ? LONG_PIX : SHORT_PIX;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int PW   = $clog2(MAXP + 1);

  tg_state_e     st;
  logic [TW-1:0] cnt, len;
  logic [2:0]    sub_cnt;
  logic [LW-1:0] line_cnt;
  logic [PW-1:0] pix_cnt;
  logic          tick_done, load;

  logic [TW-1:0] c_xfer, c_ped, c_vstep, c_hdly, c_hper, c_shut, c_gap;
  logic [LW-1:0] c_lines;
  logic [PW-1:0] c_pix;
  logic          c_bin;

  // events brought out for the checker
  logic pix_shift;
  logic xfer_end;
  logic line_end;

  assign load = (st == ST_IDLE) && start;

  ccdtg_cfg_latch #(
    .TW(TW), .MIN_XFER(MIN_XFER), .MIN_PED(MIN_PED), .MIN_VSTEP(MIN_VSTEP),
    .MIN_HDLY(MIN_HDLY), .MIN_HPER(MIN_HPER), .MIN_SHUT(MIN_SHUT), .MIN_GAP(MIN_GAP),
    .SHORT_LINES(SHORT_LINES), .SHORT_PIX(SHORT_PIX),
    .LONG_LINES(LONG_LINES), .LONG_PIX(LONG_PIX), .LW(LW), .PW(PW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .long_mode(long_mode), .bin2(bin2),
    .t_xfer(t_xfer), .t_ped(t_ped), .t_vstep(t_vstep), .t_hdly(t_hdly),
    .t_hper(t_hper), .t_shut(t_shut), .t_gap(t_gap),
    .c_xfer(c_xfer), .c_ped(c_ped), .c_vstep(c_vstep), .c_hdly(c_hdly),
    .c_hper(c_hper), .c_shut(c_shut), .c_gap(c_gap),
    .c_lines(c_lines), .c_pix(c_pix), .c_bin(c_bin)
  );

  always_comb begin
    case (st)
      ST_SHUT:                len = c_shut;
      ST_GAP:                 len = c_gap;
      ST_PLEAD, ST_PTRAIL:    len = c_ped;
      ST_PXFER:               len = c_xfer;
      ST_VSTEP:               len = c_vstep;
      ST_HDLY:                len = c_hdly;
      ST_HREAD:               len = c_hper;
      default:                len = TW'(1);
    endcase
  end

  assign tick_done = (cnt == len - TW'(1));
  assign pix_shift = (st == ST_HREAD) && tick_done;
  assign xfer_end  = (st == ST_PXFER) && tick_done;
  assign line_end  = pix_shift && (pix_cnt == c_pix - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sub_cnt  <= '0;
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else if (st == ST_IDLE) begin
      cnt      <= '0;
      sub_cnt  <= '0;
      pix_cnt  <= '0;
      line_cnt <= '0;
      if (start) st <= shutter_en ? ST_SHUT : ST_PLEAD;
    end else if (!tick_done) begin
      cnt <= cnt + TW'(1);
    end else begin
      cnt <= '0;
      case (st)
        ST_SHUT:   st <= ST_GAP;
        ST_GAP:    st <= ST_PLEAD;
        ST_PLEAD:  st <= ST_PXFER;
        ST_PXFER:  st <= ST_PTRAIL;
        ST_PTRAIL: st <= ST_VSTEP;
        ST_VSTEP: begin
          if (sub_cnt == (c_bin ? 3'd7 : 3'd3)) begin
            sub_cnt <= '0;
            st      <= ST_HDLY;
          end else begin
            sub_cnt <= sub_cnt + 3'd1;
          end
        end
        ST_HDLY:   st <= ST_HREAD;
        ST_HREAD: begin
          if (line_end) begin
            pix_cnt <= '0;
            if (line_cnt == c_lines - LW'(1)) begin
              line_cnt <= '0;
              st       <= ST_IDLE;
            end else begin
              line_cnt <= line_cnt + LW'(1);
              st       <= ST_VSTEP;
            end
          end else begin
            pix_cnt <= pix_cnt + PW'(1);
          end
        end
        default:   st <= ST_IDLE;
      endcase
    end
  end

  vlev_t vlev;

  ccdtg_vdrive u_vdrive (
    .st(st), .sub(sub_cnt[1:0]), .lev(vlev)
  );

  ccdtg_hclk #(.TW(TW)) u_hclk (
    .active(st == ST_HREAD), .phase(cnt), .hper(c_hper),
    .h1(h1), .h2(h2), .h2l(h2_last), .rg(rst_gate)
  );

  assign v1_lvl  = vlev.v1;
  assign v2      = vlev.v2;
  assign v3      = vlev.v3;
  assign v4      = vlev.v4;
  assign shutter = (st == ST_SHUT);
  assign busy    = (st != ST_IDLE);

endmodule

// File: rtl/ccdtg_chk.sv
module ccdtg_chk
  import ccdtg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic [1:0] v1_lvl,
  input logic       v4,
  input logic       h1,
  input logic       h2,
  input logic       h2_last,
  input logic       rst_gate,
  input logic       shutter,
  input logic       pix_shift,
  input logic       xfer_end
);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_v1_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v1_lvl != 2'b11);

  p_high_from_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_lvl == V1_HIGH && $past(v1_lvl) != V1_HIGH) |-> $past(v1_lvl) == V1_MID);

  p_leave_high_v4_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_lvl != V1_HIGH && $past(v1_lvl) == V1_HIGH) |-> (v4 && !$past(v4)));

  p_xfer_trail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> (v1_lvl == V1_MID && v4));

  p_vstep_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_lvl == V1_LOW) |-> (!h1 && !h2 && !rst_gate));

  p_h_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(h1 && h2));

  p_h_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!h1 && !h2 && !h2_last && !rst_gate));

  p_rg_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_gate) |=> !rst_gate);

  p_shift_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_shift |-> h2_last);

  p_shift_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_shift |=> !h2_last);

  p_shut_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shutter |-> (!h1 && !h2 && v1_lvl == V1_MID && busy));

endmodule

bind ccd_timing_gen ccdtg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .v1_lvl(v1_lvl),
  .v4(v4), .h1(h1), .h2(h2), .h2_last(h2_last), .rst_gate(rst_gate),
  .shutter(shutter), .pix_shift(pix_shift), .xfer_end(xfer_end)
);

// File: tb/tb_ccd_timing_gen.sv
module tb_ccd_timing_gen;

  localparam int TW = 8;
  localparam int MN_XFER = 2, MN_PED = 3, MN_VSTEP = 2, MN_HDLY = 2;
  localparam int MN_HPER = 2, MN_SHUT = 2, MN_GAP = 2;
  localparam int SL = 4, SP = 3, LL = 6, LP = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic long_mode = 1'b0, bin2 = 1'b0, shutter_en = 1'b0;
  logic [TW-1:0] t_xfer = '0, t_ped = '0, t_vstep = '0, t_hdly = '0;
  logic [TW-1:0] t_hper = '0, t_shut = '0, t_gap = '0;
  logic [1:0] v1_lvl;
  logic v2, v3, v4, h1, h2, h2_last, rst_gate, shutter, busy;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  ccd_timing_gen #(
    .TW(TW), .MIN_XFER(MN_XFER), .MIN_PED(MN_PED), .MIN_VSTEP(MN_VSTEP),
    .MIN_HDLY(MN_HDLY), .MIN_HPER(MN_HPER), .MIN_SHUT(MN_SHUT), .MIN_GAP(MN_GAP),
    .SHORT_LINES(SL), .SHORT_PIX(SP), .LONG_LINES(LL), .LONG_PIX(LP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode), .bin2(bin2),
    .shutter_en(shutter_en), .t_xfer(t_xfer), .t_ped(t_ped), .t_vstep(t_vstep),
    .t_hdly(t_hdly), .t_hper(t_hper), .t_shut(t_shut), .t_gap(t_gap),
    .v1_lvl(v1_lvl), .v2(v2), .v3(v3), .v4(v4), .h1(h1), .h2(h2),
    .h2_last(h2_last), .rst_gate(rst_gate), .shutter(shutter), .busy(busy)
  );

  // {busy, shutter, v1[1:0], v2, v3, v4, h1, h2, h2_last, rst_gate}
  function automatic logic [10:0] mk(input logic b, input logic s, input logic [1:0] a,
                                     input logic p2, input logic p3, input logic p4,
                                     input logic q1, input logic q2, input logic r);
    return {b, s, a, p2, p3, p4, q1, q2, q2, r};
  endfunction

  function automatic int atleast(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  task automatic push(input logic [10:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // monitor: pops one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [10:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {busy, shutter, v1_lvl, v2, v3, v4, h1, h2, h2_last, rst_gate};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s at %0t: actual %b expected %b", t, $time, a, e);
      end
    end
  end

  // driver: computes the whole frame from the requirements, then starts it
  task automatic run_frame(input logic lm, input logic bn, input logic se,
                           input int xf, input int pd, input int vs, input int hd,
                           input int hp, input int sh, input int gp, input bit poke);
    int exf, epd, evs, ehd, ehp, esh, egp, nl, np, ns;
    logic [1:0] sv1[4];
    logic       sv2[4], sv3[4], sv4[4];
    sv1 = '{2'b01, 2'b00, 2'b00, 2'b01};
    sv2 = '{1'b1, 1'b1, 1'b0, 1'b0};
    sv3 = '{1'b1, 1'b1, 1'b1, 1'b0};
    sv4 = '{1'b0, 1'b0, 1'b1, 1'b1};
    exf = atleast(xf, MN_XFER); epd = atleast(pd, MN_PED);
    evs = atleast(vs, MN_VSTEP); ehd = atleast(hd, MN_HDLY);
    ehp = atleast(atleast(hp, MN_HPER), 2); esh = atleast(sh, MN_SHUT);
    egp = atleast(gp, MN_GAP);
    nl = lm ? LL : SL;
    np = lm ? LP : SP;
    if (bn) nl = nl / 2;   // R6
    ns = bn ? 8 : 4;
    @(posedge clk); #1;
    push(mk(0,0,2'b01,1,0,0,0,0,0), "R2 idle before start");
    if (se) begin
      for (int i = 0; i < esh; i++) push(mk(1,1,2'b01,1,0,0,0,0,0), "R10 shutter pulse");
      for (int i = 0; i < egp; i++) push(mk(1,0,2'b01,1,0,0,0,0,0), "R10 guard gap");
    end
    for (int i = 0; i < epd; i++) push(mk(1,0,2'b01,1,0,0,0,0,0), "R3 lead pedestal");
    for (int i = 0; i < exf; i++) push(mk(1,0,2'b10,1,0,0,0,0,0), "R3 transfer high");
    for (int i = 0; i < epd; i++) push(mk(1,0,2'b01,1,0,1,0,0,0), "R3 trail pedestal");
    for (int ln = 0; ln < nl; ln++) begin
      for (int s = 0; s < ns; s++)
        for (int i = 0; i < evs; i++)
          push(mk(1,0,sv1[s%4],sv2[s%4],sv3[s%4],sv4[s%4],0,0,0),
               bn ? "R6 binned step" : "R5 vertical step");
      for (int i = 0; i < ehd; i++) push(mk(1,0,2'b01,1,0,0,0,0,0), "R7 settle delay");
      for (int px = 0; px < np; px++)
        for (int p = 0; p < ehp; p++)
          push(mk(1,0,2'b01,1,0,0, p < (ehp+1)/2, p >= (ehp+1)/2, p == 0),
               lm ? "R9 long pixel" : "R8 pixel");
    end
    push(mk(0,0,2'b01,1,0,0,0,0,0), "R11 busy falls");
    long_mode = lm; bin2 = bn; shutter_en = se;
    t_xfer = TW'(xf); t_ped = TW'(pd); t_vstep = TW'(vs); t_hdly = TW'(hd);
    t_hper = TW'(hp); t_shut = TW'(sh); t_gap = TW'(gp);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // R2: a second request and new counts mid-frame must change nothing
      repeat (4) @(posedge clk);
      #1;
      start = 1'b1; long_mode = ~lm; bin2 = ~bn; shutter_en = ~se;
      t_hper = TW'(hp + 3); t_vstep = TW'(vs + 2); t_ped = TW'(pd + 1);
      @(posedge clk); #1;
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected frame end");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    for (int i = 0; i < 2; i++) push(mk(0,0,2'b01,1,0,0,0,0,0), "R1 in reset");
    wait (exp_q.size() == 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) push(mk(0,0,2'b01,1,0,0,0,0,0), "R1 after reset");
    wait (exp_q.size() == 0);
    // short, plain, no shutter (R10 absent pulse), even pixel period
    run_frame(1'b0, 1'b0, 1'b0, 3, 4, 2, 3, 4, 2, 2, 1'b0);
    // long, shutter on, odd pixel period
    run_frame(1'b1, 1'b0, 1'b1, 2, 3, 3, 2, 3, 3, 4, 1'b0);
    // short binned, all counts below minimum (R4), second start mid-frame (R2)
    run_frame(1'b0, 1'b1, 1'b1, 0, 1, 0, 0, 1, 1, 0, 1'b1);
    // long binned, shutter on, wide pixels
    run_frame(1'b1, 1'b1, 1'b1, 4, 3, 2, 5, 5, 2, 3, 1'b0);
    @(posedge clk); #1;
    push(mk(0,0,2'b01,1,0,0,0,0,0), "R11 idle after last frame");
    wait (exp_q.size() == 0);
    @(posedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule